// File: doc/BRIEF.md
# Collision-Aware Pipeline Admission Controller

This block decides, cycle by cycle, whether a new task may be launched into a static pipeline whose stages are reused over several cycles. The caller supplies a forbidden-latency mask. Bit i-1 of the mask is 1 when launching a second task exactly i cycles after a first one would make the two tasks claim the same stage in the same cycle. The controller keeps a collision-state word. That word moves one position toward bit 0 on every clock, so each shift stands for one more cycle of elapsed latency. Bit 0 of the word says whether launching in the current cycle would collide with any task already in flight.

A requester raises `req` and holds it until `grant` comes back. A grant is issued in the same cycle as the request whenever bit 0 of the state is clear. On that clock edge the shifted state absorbs the mask by a bitwise OR. The block therefore admits work greedily, at the earliest cycle that causes no collision. With the mask 1011010 and a request held high without a break, the spacing between launches settles into the repeating pattern 1, 8, 1, 8. A count of the cycles since the last launch is also provided, and it stops counting at one past the mask width.

Top module: `ici_ctrl`

## Requirements
- R1: While the internal reset is asserted, and on the first cycle after it is released, `state` is all zeros, `lat_cnt` equals VEC_W+1 and `grant` is 0. Once reset is released, the first request is granted in the cycle it is raised.
- R2: `grant` is 1 in a cycle exactly when `req` is 1 and `state[0]` is 0. It is combinational, with no register between `req` and `grant`.
- R3: After a cycle with `grant`=1, the next `state` equals the previous `state` shifted right by one, with a zero entering at bit VEC_W-1, OR-ed with `forbid_vec`. For the mask 1011010, a grant at latency 1 therefore produces 1111111.
- R4: After a cycle with `grant`=0, the next `state` equals the previous `state` shifted right by one, with zero fill.
- R5: `lat_cnt` is 1 in the cycle after a grant. It rises by one in every cycle without a grant, so a grant issued while `lat_cnt`=k is a launch at latency k.
- R6: `lat_cnt` never exceeds VEC_W+1 and holds at that value until the next grant.
- R7: A request held high is granted at the earliest cycle whose `state[0]` is 0, and never in a cycle where the latency since the last grant is marked forbidden in `forbid_vec`. With mask 1011010, the latencies seen at successive grants are 1, 8, 1, 8.
- R8: After an idle gap longer than VEC_W cycles, `state` is all zeros. A grant issued then leaves `state` equal to `forbid_vec` exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| req | input | 1 | Launch request, held high until granted |
| forbid_vec | input | VEC_W | Forbidden-latency mask; bit i-1 set means latency i collides |
| grant | output | 1 | Launch permitted in this cycle |
| state | output | VEC_W | Current collision-state word; bit 0 applies to the current cycle |
| lat_cnt | output | $clog2(VEC_W+2) | Cycles since the last grant, saturating at VEC_W+1 |

## Verification
The bench tracks the mask 1011010 through a held request. It checks that the first two launches come one cycle apart and that the next one comes eight cycles later. A design that left out the OR-in would admit the third launch too early, and a design that shifted the wrong way would stall or collide. Long idle gaps are used to catch a counter that wraps instead of holding, and a state that fails to reload exactly to the mask. Random masks and random request patterns, including an all-zero mask, exercise an off-by-one in the shift and a grant that arrives a cycle late because it was registered. Requests raised during reset expose a grant that is not gated by reset.

// File: rtl/ici_pkg.sv
package ici_pkg;

  // Next collision-state word: one cycle of elapsed latency, plus the
  // mask merged in when a launch is taken on this edge.
  function automatic logic [63:0] advance_word(input logic [63:0] cur,
                                               input logic [63:0] mask,
                                               input logic        take);
    logic [63:0] shifted;
    shifted = cur >> 1;
    return take ? (shifted | mask) : shifted;
  endfunction

endpackage

// File: rtl/ici_rst_sync.sv
module ici_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ici_state.sv
module ici_state
  import ici_pkg::*;
#(
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [VEC_W-1:0] forbid_vec,
  output logic [VEC_W-1:0] st
);
  logic [VEC_W-1:0] st_q;
  logic [VEC_W-1:0] st_d;
  logic [63:0]      wide_next;

  always_comb begin
    wide_next = advance_word(64'(st_q), 64'(forbid_vec), take);
    st_d      = wide_next[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R3: a launch leaves every bit of the mask set in the new state
  a_r3_or_in: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((st_q & $past(forbid_vec)) == $past(forbid_vec)));

  // R4: with no launch, the word only moves toward bit 0
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (st_q == ($past(st_q) >> 1)));
endmodule

// File: rtl/ici_latcnt.sv
module ici_latcnt #(
  parameter int VEC_W = 7,
  parameter int CNT_W = $clog2(VEC_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(VEC_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = take | (cnt_q != SAT);
    cnt_d  = take ? CNT_W'(1) : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= SAT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt_q == CNT_W'(1)));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && cnt_q != SAT) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT);
endmodule

// File: rtl/ici_ctrl.sv
module ici_ctrl #(
  parameter int VEC_W     = 7,
  parameter int CNT_W     = $clog2(VEC_W + 2),
  parameter int RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [VEC_W-1:0] forbid_vec,
  output logic             grant,
  output logic [VEC_W-1:0] state,
  output logic [CNT_W-1:0] lat_cnt
);
  logic             rst_sync_n;
  logic [VEC_W-1:0] st;
  logic [CNT_W-1:0] cnt;

  ici_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    grant = req & ~st[0] & rst_sync_n;
  end

  ici_state #(.VEC_W(VEC_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .take       (grant),
    .forbid_vec (forbid_vec),
    .st         (st)
  );

  ici_latcnt #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .take  (grant),
    .cnt   (cnt)
  );

  assign state   = st;
  assign lat_cnt = cnt;

  // Checker: the latency since the last launch must not be marked forbidden
  logic last_ok;
  always_comb begin
    last_ok = 1'b1;
    for (int i = 0; i < VEC_W; i++) begin
      if (cnt == CNT_W'(i + 1) && forbid_vec[i]) last_ok = 1'b0;
    end
  end

  a_r7_no_collision: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grant |-> last_ok);

  a_r1_gated: assert property (@(posedge clk)
    !rst_sync_n |-> !grant);
endmodule

// File: tb/sim_ici_ctrl.sv
`timescale 1ns/1ps
module sim_ici_ctrl;
  localparam int M  = 7;
  localparam int CW = $clog2(M + 2);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req;
  logic [M-1:0]  fv;
  logic          grant;
  logic [M-1:0]  state;
  logic [CW-1:0] lat_cnt;

  int total = 0;
  int bad   = 0;

  logic [M-1:0] m_st;
  int           m_cnt;

  always #2.5 clk = ~clk;

  ici_ctrl #(.VEC_W(M)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .forbid_vec(fv),
    .grant(grant), .state(state), .lat_cnt(lat_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_grant(input bit r);
    return r && !m_st[0];
  endfunction

  // One cycle: drive, check the outputs against the model, advance the model.
  task automatic step(input bit r);
    bit g;
    @(negedge clk);
    req = r;
    #1;
    g = exp_grant(r);
    chk(grant === g, "R2 grant", int'(grant), int'(g));
    chk(state === m_st, "R3/R4 state", int'(state), int'(m_st));
    chk(int'(lat_cnt) == m_cnt, "R5/R6 lat_cnt", int'(lat_cnt), m_cnt);
    if (g) begin
      m_st  = (m_st >> 1) | fv;
      m_cnt = 1;
    end else begin
      m_st = m_st >> 1;
      if (m_cnt < M + 1) m_cnt++;
    end
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = 1'b1;
    #1;
    chk(grant === 1'b0, "R1 grant during reset", int'(grant), 0);
    chk(state === '0, "R1 state during reset", int'(state), 0);
    chk(int'(lat_cnt) == M + 1, "R1 lat_cnt during reset", int'(lat_cnt), M + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req   = 1'b0;
    repeat (3) @(posedge clk);
    m_st  = '0;
    m_cnt = M + 1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lats[$];
    rst_n = 1'b0;
    req   = 1'b0;
    fv    = 7'b1011010;
    void'($urandom(32'd4711));
    do_reset();

    // R1: the first request is granted at once
    @(negedge clk); #1;
    chk(state === '0 && int'(lat_cnt) == M + 1, "R1 state after release", int'(state), 0);
    req = 1'b1; #1;
    chk(grant === 1'b1, "R1 first request granted", int'(grant), 1);
    req = 1'b0;

    // R7: greedy launch spacing under a held request
    do_reset();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      req = 1'b1; #1;
      if (grant) lats.push_back(int'(lat_cnt));
      if (i == 2) chk(state === 7'b1111111, "R3 OR-in after latency 1", int'(state), 127);
      @(posedge clk);
    end
    chk(lats.size() >= 6, "R7 grant count", lats.size(), 6);
    for (int k = 1; k < 6 && k < lats.size(); k++)
      chk(lats[k] == ((k % 2 == 1) ? 1 : 8), "R7 greedy latency", lats[k], (k % 2 == 1) ? 1 : 8);

    // R8 / R6: long idle gap, then a launch reloads the mask exactly
    @(negedge clk); req = 1'b0;
    repeat (12) @(negedge clk);
    #1;
    chk(state === '0, "R8 state empty after gap", int'(state), 0);
    chk(int'(lat_cnt) == M + 1, "R6 lat_cnt saturated", int'(lat_cnt), M + 1);
    req = 1'b1; #1;
    chk(grant === 1'b1, "R8 grant after gap", int'(grant), 1);
    @(negedge clk); req = 1'b0; #1;
    chk(state === fv, "R8 state equals mask", int'(state), int'(fv));
    chk(int'(lat_cnt) == 1, "R5 lat_cnt after grant", int'(lat_cnt), 1);

    // Model-checked directed and random phases
    fv = 7'b1001010; do_reset();
    for (int i = 0; i < 60; i++) step(1'b1);
    fv = 7'b0000000; do_reset();
    for (int i = 0; i < 40; i++) step(($urandom % 2) == 1);
    for (int ph = 0; ph < 8; ph++) begin
      fv = M'($urandom);
      do_reset();
      for (int i = 0; i < 1500; i++) step(($urandom % 4) != 0 || (i % 97) > 80);
      for (int i = 0; i < 12; i++) step(1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule